// File: doc/BRIEF.md
# External Bus Turnaround Wait-State Scheduler

This block paces the accesses that an internal requester sends toward a shared static-memory bus. A device on that bus needs some cycles to release the data lines once it is deselected. The block keeps one countdown of that release time, loaded from a programmed value for each chip select. From that countdown and from the previous external access, it works out how many idle cycles to insert before it accepts each new request. The two kinds of idle cycle are float cycles, which let the last device release the bus, and a single device-change cycle, used when the next external access goes to a different chip select.

Accesses to internal memory never wait. The float countdown keeps running while they are served, so a later external access waits only for what is left of it. A read that follows a read to the same chip select does not wait for float time. When a device change and pending float time apply to the same request, the delay is the larger of the two and the two are never added. The requester holds a request stable under a valid/ready handshake. Ready stays low for exactly the computed number of idle cycles and then goes high for one cycle, and that cycle starts the access. From the point of view of this block, an access ends in its grant cycle.

Top module: `bts_sched`

## Requirements
- R1: While reset is asserted and after it is released with no request pending, `req_ready_o` and `busy_o` are both 0.
- R2: A request with `req_ext_i`=0 (internal) is granted in the cycle it first appears, even while float time is pending.
- R3: The granting of an external access loads the float countdown with the 4-bit value in `float_cfg_i[4*cs +: 4]` of that access's chip select. The countdown then drops by one on each later cycle until it reaches 0, and internal grants and idle cycles do not pause it.
- R4: An external access waits for the remaining float count unless it is exempt under R5. This covers a write after any access, a read after a write, and any access to a different chip select.
- R5: An external read (`req_write_i`=0) that follows an external read to the same chip select inserts no float cycles, whatever count remains.
- R6: An external access to a chip select different from the previous external one, with no float time remaining, waits exactly one idle cycle.
- R7: When a device change and remaining float count F>0 both apply, the delay is F cycles and not F+1.
- R8: The first external access after reset has no device-change cycle and no float cycles.
- R9: For a request that needs D idle cycles, `req_ready_o` is 0 and `busy_o` is 1 for exactly D cycles. Then `req_ready_o` is 1 and `busy_o` is 0 for the grant cycle.
- R10: A chip select programmed with float value 0 leaves no float wait for the next access to the same chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; held stable until granted |
| req_ext_i | input | 1 | 1 = external chip select access, 0 = internal memory |
| req_cs_i | input | CS_W | Target chip select for external access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| float_cfg_i | input | NUM_CS*FLOAT_W | Float time per chip select, FLOAT_W bits each, chip select n at bits n*FLOAT_W upward |
| req_ready_o | output | 1 | Grant: the access starts in this cycle |
| busy_o | output | 1 | An idle cycle is being inserted for the pending request |

## Verification
The assertions watch the local timing rules on every cycle. They check that internal and first-after-reset requests are granted at once, that the float countdown drops by one per cycle, that a device change always follows at least one idle cycle, and that no non-exempt external grant happens while float time is left. Only the bench's sequences can show the exact length of each delay. These include a countdown that is partly used up by internal accesses, a delay taken as the maximum of float time and device change rather than their sum, and a read-after-read exemption that holds even with a large count pending. The bench's behavioural model predicts ready and busy on every cycle of those sequences.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic {
    PH_EVAL = 1'b0,
    PH_WAIT = 1'b1
  } pace_phase_e;

endpackage

// File: rtl/bts_float_tracker.sv
module bts_float_tracker #(
  parameter int NUM_CS  = 4,
  parameter int FLOAT_W = 4,
  parameter int CS_W    = $clog2(NUM_CS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [CS_W-1:0]             cs_i,
  input  logic [NUM_CS*FLOAT_W-1:0]   cfg_i,
  output logic [FLOAT_W-1:0]          cnt_o
);

  logic [FLOAT_W-1:0] cfg_arr [NUM_CS];
  logic [FLOAT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    assign cfg_arr[g] = cfg_i[g*FLOAT_W +: FLOAT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= cfg_arr[cs_i];
    else if (cnt_q != '0)     cnt_q <= cnt_q - FLOAT_W'(1);
  end

  assign cnt_o = cnt_q;

  p_float_decrement_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - FLOAT_W'(1)));

endmodule

// File: rtl/bts_history.sv
module bts_history #(
  parameter int CS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic            write_i,
  output logic            vld_o,
  output logic [CS_W-1:0] cs_o,
  output logic            rd_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      cs_o  <= '0;
      rd_o  <= 1'b0;
    end else if (upd_i) begin
      vld_o <= 1'b1;
      cs_o  <= cs_i;
      rd_o  <= !write_i;
    end
  end

endmodule

// File: rtl/bts_delay_calc.sv
module bts_delay_calc #(
  parameter int CS_W    = 2,
  parameter int FLOAT_W = 4
) (
  input  logic               ext_i,
  input  logic [CS_W-1:0]    cs_i,
  input  logic               write_i,
  input  logic               hist_vld_i,
  input  logic [CS_W-1:0]    hist_cs_i,
  input  logic               hist_rd_i,
  input  logic [FLOAT_W-1:0] float_cnt_i,
  output logic               rr_skip_o,
  output logic               cs_chg_o,
  output logic [FLOAT_W-1:0] delay_o
);

  logic               same_cs;
  logic [FLOAT_W-1:0] float_d;

  always_comb begin
    same_cs   = hist_vld_i && (cs_i == hist_cs_i);
    rr_skip_o = same_cs && hist_rd_i && !write_i;
    cs_chg_o  = hist_vld_i && !same_cs;
    float_d   = rr_skip_o ? '0 : float_cnt_i;
    if (!ext_i)                         delay_o = '0;
    else if (cs_chg_o && float_d == '0) delay_o = FLOAT_W'(1);
    else                                delay_o = float_d;
  end

endmodule

// File: rtl/bts_pacer.sv
module bts_pacer
  import bts_pkg::*;
#(
  parameter int FLOAT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FLOAT_W-1:0] delay_i,
  output logic               ready_o,
  output logic               busy_o,
  output logic               waiting_o
);

  pace_phase_e        phase_q;
  logic [FLOAT_W-1:0] wait_q;

  always_comb begin
    if (phase_q == PH_EVAL) ready_o = valid_i && (delay_i == '0);
    else                    ready_o = valid_i && (wait_q == '0);
    busy_o    = valid_i && !ready_o;
    waiting_o = (phase_q == PH_WAIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_EVAL;
      wait_q  <= '0;
    end else if (phase_q == PH_EVAL) begin
      if (valid_i && delay_i != '0) begin
        phase_q <= PH_WAIT;
        wait_q  <= delay_i - FLOAT_W'(1);
      end
    end else if (wait_q != '0) begin
      wait_q <= wait_q - FLOAT_W'(1);
    end else begin
      phase_q <= PH_EVAL;
    end
  end

  p_hold_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && wait_q != '0) |-> !ready_o);

  p_wait_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && wait_q != '0) |=> (phase_q == PH_WAIT));

endmodule

// File: rtl/bts_sched.sv
module bts_sched #(
  parameter int NUM_CS  = 4,
  parameter int FLOAT_W = 4,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CFG_W  = NUM_CS * FLOAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_ext_i,
  input  logic [CS_W-1:0]  req_cs_i,
  input  logic             req_write_i,
  input  logic [CFG_W-1:0] float_cfg_i,
  output logic             req_ready_o,
  output logic             busy_o
);

  logic               fire_ext;
  logic [FLOAT_W-1:0] float_cnt;
  logic               hist_vld;
  logic [CS_W-1:0]    hist_cs;
  logic               hist_rd;
  logic               rr_skip;
  logic               cs_chg;
  logic [FLOAT_W-1:0] delay;
  logic               waiting;

  assign fire_ext = req_valid_i && req_ready_o && req_ext_i;

  bts_float_tracker #(
    .NUM_CS (NUM_CS),
    .FLOAT_W(FLOAT_W),
    .CS_W   (CS_W)
  ) u_float (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(fire_ext),
    .cs_i  (req_cs_i),
    .cfg_i (float_cfg_i),
    .cnt_o (float_cnt)
  );

  bts_history #(
    .CS_W(CS_W)
  ) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (fire_ext),
    .cs_i   (req_cs_i),
    .write_i(req_write_i),
    .vld_o  (hist_vld),
    .cs_o   (hist_cs),
    .rd_o   (hist_rd)
  );

  bts_delay_calc #(
    .CS_W   (CS_W),
    .FLOAT_W(FLOAT_W)
  ) u_calc (
    .ext_i      (req_ext_i),
    .cs_i       (req_cs_i),
    .write_i    (req_write_i),
    .hist_vld_i (hist_vld),
    .hist_cs_i  (hist_cs),
    .hist_rd_i  (hist_rd),
    .float_cnt_i(float_cnt),
    .rr_skip_o  (rr_skip),
    .cs_chg_o   (cs_chg),
    .delay_o    (delay)
  );

  bts_pacer #(
    .FLOAT_W(FLOAT_W)
  ) u_pace (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .delay_i  (delay),
    .ready_o  (req_ready_o),
    .busy_o   (busy_o),
    .waiting_o(waiting)
  );

  p_internal_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ext_i && !waiting) |-> req_ready_o);

  p_float_drained_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_ext && !rr_skip) |-> (float_cnt == '0));

  p_change_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_ext && cs_chg) |-> $past(busy_o));

  p_first_ext_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ext_i && !hist_vld && !waiting) |-> req_ready_o);

endmodule

// File: tb/bts_sched_bench.sv
`timescale 1ns/100ps
module bts_sched_bench;

  localparam int NUM_CS  = 4;
  localparam int FLOAT_W = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       ext = 1'b0;
  logic [1:0] cs = '0;
  logic       wr = 1'b0;
  logic [15:0] cfg_bus;
  logic       ready;
  logic       busy;

  int cfg_m [NUM_CS] = '{3, 5, 0, 15};
  int m_float = 0;
  int m_last_cs = -1;
  bit m_last_rd = 1'b0;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    assign cfg_bus[g*4 +: 4] = 4'(cfg_m[g]);
  end

  bts_sched #(.NUM_CS(NUM_CS), .FLOAT_W(FLOAT_W)) u_bts_sched (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(valid),
    .req_ext_i  (ext),
    .req_cs_i   (cs),
    .req_write_i(wr),
    .float_cfg_i(cfg_bus),
    .req_ready_o(ready),
    .busy_o     (busy)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit fire, bit e, int c, bit w);
    if (fire && e) begin
      m_float   = cfg_m[c];
      m_last_cs = c;
      m_last_rd = !w;
    end else if (m_float > 0) begin
      m_float--;
    end
  endtask

  function automatic int expect_delay(bit e, int c, bit w);
    int fl;
    bit chg;
    if (!e) return 0;
    fl  = (m_last_cs == c && m_last_rd && !w) ? 0 : m_float;
    chg = (m_last_cs >= 0) && (m_last_cs != c);
    if (chg && fl == 0) return 1;
    return fl;
  endfunction

  task automatic access(bit e, int c, bit w, string req);
    int d;
    d = expect_delay(e, c, w);
    @(negedge clk);
    valid = 1'b1; ext = e; cs = 2'(c); wr = w;
    for (int k = 0; k <= d; k++) begin
      #1;
      chk(ready == (k == d), req, "ready", int'(ready), int'(k == d));
      chk(busy == (k < d), req, "busy", int'(busy), int'(k < d));
      @(posedge clk);
      step(k == d, e, c, w);
      if (k < d) @(negedge clk);
    end
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
      #1;
      chk(!ready, req, "idle ready", int'(ready), 0);
      chk(!busy, req, "idle busy", int'(busy), 0);
      @(posedge clk);
      step(1'b0, 1'b0, 0, 1'b0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!ready, "R1", "reset ready", int'(ready), 0);
    chk(!busy, "R1", "reset busy", int'(busy), 0);
    rst_n = 1'b1;
    idle(2, "R1");

    access(1, 0, 0, "R8");        // first external, no wait
    access(1, 0, 0, "R5");        // read after read, same cs
    access(0, 0, 0, "R2");        // internal while float pending
    access(1, 0, 1, "R3");        // write waits remaining float only
    access(1, 0, 0, "R4");        // read after write waits full float
    idle(4, "R3");
    access(1, 1, 0, "R6");        // device change, float drained
    access(1, 2, 1, "R7");        // change plus float 5: delay 5
    access(1, 2, 1, "R10");       // float value 0, same cs
    access(1, 3, 0, "R6");
    access(0, 1, 0, "R2");
    access(0, 2, 1, "R2");
    access(0, 0, 0, "R2");
    access(1, 3, 0, "R5");        // read after read, count pending
    access(1, 0, 1, "R7");        // change plus float 15: delay 15
    access(1, 0, 1, "R4");        // write after write waits float 3
    idle(3, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule